// File: doc/BRIEF.md
# Byte-Lane Asynchronous Static RAM Controller

This block is a clocked sequencer that turns single-word requests from an internal valid/ready port into correctly timed strobe sequences for an external asynchronous static RAM. The RAM word is split into equal lanes. Each lane has its own active-low chip enable, and the RAM also takes a shared active-low write strobe and a shared active-low output enable. A request carries a word address, write data, a lane mask and a read/write flag. The controller holds the address, opens only the lanes in the mask, sequences the strobes and steers the direction of the data bus. It returns read data with a one-cycle valid strobe.

Every RAM timing minimum is a parameter in picoseconds. At elaboration each one is turned into a whole number of clock cycles by rounding up against the clock-period parameter, and no phase is shorter than one cycle. The states are:

- `ST_PWR_WAIT`: the supply-settling wait after reset.
- `ST_IDLE`: ready for a request, bus deselected.
- `ST_WR_TURN`: write strobe low, drivers still off.
- `ST_WR_DRIVE`: write strobe low, data driven.
- `ST_WR_END`: write strobe high, lanes and data still held.
- `ST_RD_ACC`: read access.

The transitions are:

- `ST_PWR_WAIT`→`ST_IDLE` when the wait counter expires.
- `ST_IDLE`→`ST_WR_TURN` on an accepted write with a non-zero mask.
- `ST_IDLE`→`ST_RD_ACC` on an accepted read with a non-zero mask.
- `ST_IDLE`→`ST_IDLE` on an accepted request with a zero mask.
- `ST_WR_TURN`→`ST_WR_DRIVE` after NT cycles.
- `ST_WR_DRIVE`→`ST_WR_END` after ND cycles.
- `ST_WR_END`→`ST_IDLE` after one cycle.
- `ST_RD_ACC`→`ST_IDLE` after NA cycles, with a read sample taken on that edge.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset is released, `req_ready` stays low for at least NP = ceil(T_PWRUP_PS/CLK_PS) cycles. During that time every lane enable, `ram_we_n` and `ram_oe_n` are high and `ram_dq_oe` is low.
- R2: A write lowers `ram_we_n` together with the selected lane enables. The data drivers (`ram_dq_oe`) stay off for the first NT = ceil(T_HZWE_PS/CLK_PS) cycles of the low strobe.
- R3: The write strobe is low for exactly NT+ND cycles, and the data is driven for the last ND of them. ND is the largest of ceil(T_SD), ceil(T_PWE)−NT, ceil(T_AW)−NT, ceil(T_WC)−NT−1 and 1, each ceil taken in cycles.
- R4: `ram_we_n` rises one cycle before the lane enables rise and the drivers turn off. Address, lane enables and data are unchanged across the cycle in which it rises.
- R5: `ram_oe_n` is high whenever `ram_we_n` is low. `ram_dq_oe` is never high while `ram_oe_n` is low.
- R6: Lane i covers data bits [8i+7:8i], and mask bit i selects it. Only lanes whose mask bit is 1 have their enable low `ram_ce_n[i]`. A partial write leaves the other lanes of the word unchanged.
- R7: A read holds the selected enables low, `ram_oe_n` low and `ram_we_n` high for NA cycles. NA is the largest of ceil(T_AA), ceil(T_DOE) and ceil(T_RC). The data is sampled at the edge that ends the last of those cycles, and `rsp_valid` is high for one cycle directly after that edge.
- R8: In read data, the bits of lanes whose mask bit is 0 are returned as zero.
- R9: A request with an all-zero mask touches no lane enable, and `req_ready` is high again in the next cycle. A read with an all-zero mask gives `rsp_valid` with all-zero data in the cycle after it is accepted. A write with an all-zero mask gives no response.
- R10: `req_ready` is high only in idle, with all lane enables high. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and its fields are captured on that edge, so later changes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (19) | Word address |
| req_wdata | input | DATA_W (24) | Write data |
| req_lanes | input | LANES (3) | Lane mask, bit i selects data bits [8i+7:8i] |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | DATA_W (24) | Read data, unselected lanes zero |
| ram_addr | output | ADDR_W (19) | RAM address |
| ram_ce_n | output | LANES (3) | Active-low lane enables |
| ram_we_n | output | 1 | Active-low write strobe |
| ram_oe_n | output | 1 | Active-low output enable |
| ram_dq_out | output | DATA_W (24) | Data toward the RAM |
| ram_dq_oe | output | 1 | Data driver enable for the bidirectional pad |
| ram_dq_in | input | DATA_W (24) | Data from the RAM |

## Verification
A state register stuck in or skipping a phase shows up at the RAM pins at once. The write strobe then stays low for a cycle count other than NT+ND, or the drivers come on during the turnaround. The bench measures both counts at every rising edge of the strobe. A miscounted read sample is exposed within the same access: the bench's RAM model returns a filler pattern until the last access cycle, so an early sample is caught at the next response. A wrong latched mask shows up as corrupted neighbour lanes or non-zero unselected lanes on the next read-back of that word.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_PWR_WAIT,
        ST_IDLE,
        ST_WR_TURN,
        ST_WR_DRIVE,
        ST_WR_END,
        ST_RD_ACC
    } ctrl_state_e;

    // picoseconds to whole cycles, rounded up, never below one
    function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_lane_timer.sv
module sram_lane_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_powerup.sv
module sram_lane_powerup #(
    parameter int WAIT_CYC = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic settled
);

    localparam int PW = $clog2(WAIT_CYC + 1);

    logic [PW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != PW'(WAIT_CYC)) begin
            cnt_q <= cnt_q + PW'(1);
        end
    end

    assign settled = (cnt_q == PW'(WAIT_CYC));

endmodule

// File: rtl/sram_lane_capture.sv
module sram_lane_capture #(
    parameter int LANES  = 3,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample,
    input  logic [LANES-1:0]         lanes,
    input  logic [LANES*LANE_W-1:0]  dq_in,
    output logic                     rsp_valid,
    output logic [LANES*LANE_W-1:0]  rsp_data
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= sample;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rsp_data[l*LANE_W +: LANE_W] <= '0;
            end else if (sample) begin
                rsp_data[l*LANE_W +: LANE_W] <= lanes[l] ? dq_in[l*LANE_W +: LANE_W]
                                                         : '0;
            end
        end
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int LANES       = 3,
    parameter int LANE_W      = 8,
    parameter int CLK_PS      = 5000,
    parameter int T_PWRUP_PS  = 1_000_000_000,
    parameter int T_HZWE_PS   = 5000,
    parameter int T_SD_PS     = 5500,
    parameter int T_PWE_PS    = 7000,
    parameter int T_AW_PS     = 7000,
    parameter int T_WC_PS     = 10000,
    parameter int T_AA_PS     = 10000,
    parameter int T_DOE_PS    = 5000,
    parameter int T_RC_PS     = 10000,
    localparam int DATA_W     = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_lanes,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [LANES-1:0]  ram_ce_n,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);

    // phase lengths in cycles
    localparam int NP = ps_to_cyc(T_PWRUP_PS, CLK_PS);
    localparam int NT = ps_to_cyc(T_HZWE_PS, CLK_PS);
    localparam int ND = imax(imax(ps_to_cyc(T_SD_PS, CLK_PS),
                                  ps_to_cyc(T_PWE_PS, CLK_PS) - NT),
                             imax(imax(ps_to_cyc(T_AW_PS, CLK_PS) - NT,
                                       ps_to_cyc(T_WC_PS, CLK_PS) - NT - 1),
                                  1));
    localparam int NA = imax(imax(ps_to_cyc(T_AA_PS, CLK_PS),
                                  ps_to_cyc(T_DOE_PS, CLK_PS)),
                             ps_to_cyc(T_RC_PS, CLK_PS));
    localparam int NMAX = imax(imax(NT, ND), NA);
    localparam int TW   = imax($clog2(NMAX + 1), 1);

    ctrl_state_e state_q, state_d;

    logic              accept;
    logic              settled;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_done;
    logic              sample_rd;
    logic [LANES-1:0]  cap_lanes;

    logic [ADDR_W-1:0] lat_addr_q;
    logic [DATA_W-1:0] lat_data_q;
    logic [LANES-1:0]  lat_lanes_q;

    assign accept = req_valid && req_ready;

    sram_lane_powerup #(
        .WAIT_CYC (NP)
    ) pwr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .settled (settled)
    );

    sram_lane_timer #(
        .TW (TW)
    ) tmr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    // request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_addr_q  <= '0;
            lat_data_q  <= '0;
            lat_lanes_q <= '0;
        end else if (accept) begin
            lat_addr_q  <= req_addr;
            lat_data_q  <= req_wdata;
            lat_lanes_q <= req_lanes;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PWR_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state, phase timer loads and read sample
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        sample_rd = 1'b0;
        unique case (state_q)
            ST_PWR_WAIT: begin
                if (settled) begin
                    state_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (accept) begin
                    if (req_lanes == '0) begin
                        sample_rd = !req_write;
                    end else if (req_write) begin
                        state_d  = ST_WR_TURN;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(NT - 1);
                    end else begin
                        state_d  = ST_RD_ACC;
                        tmr_load = 1'b1;
                        tmr_val  = TW'(NA - 1);
                    end
                end
            end
            ST_WR_TURN: begin
                if (tmr_done) begin
                    state_d  = ST_WR_DRIVE;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(ND - 1);
                end
            end
            ST_WR_DRIVE: begin
                if (tmr_done) begin
                    state_d = ST_WR_END;
                end
            end
            ST_WR_END: begin
                state_d = ST_IDLE;
            end
            ST_RD_ACC: begin
                if (tmr_done) begin
                    state_d   = ST_IDLE;
                    sample_rd = 1'b1;
                end
            end
            default: begin
                state_d = ST_PWR_WAIT;
            end
        endcase
    end

    // pin outputs decoded from state
    always_comb begin
        req_ready  = 1'b0;
        ram_ce_n   = '1;
        ram_we_n   = 1'b1;
        ram_oe_n   = 1'b1;
        ram_dq_oe  = 1'b0;
        unique case (state_q)
            ST_PWR_WAIT: begin
            end
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_WR_TURN: begin
                ram_ce_n = ~lat_lanes_q;
                ram_we_n = 1'b0;
            end
            ST_WR_DRIVE: begin
                ram_ce_n  = ~lat_lanes_q;
                ram_we_n  = 1'b0;
                ram_dq_oe = 1'b1;
            end
            ST_WR_END: begin
                ram_ce_n  = ~lat_lanes_q;
                ram_dq_oe = 1'b1;
            end
            ST_RD_ACC: begin
                ram_ce_n = ~lat_lanes_q;
                ram_oe_n = 1'b0;
            end
            default: begin
            end
        endcase
    end

    assign ram_addr   = lat_addr_q;
    assign ram_dq_out = lat_data_q;
    assign cap_lanes  = (state_q == ST_IDLE) ? req_lanes : lat_lanes_q;

    sram_lane_capture #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) cap_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (sample_rd),
        .lanes     (cap_lanes),
        .dq_in     (ram_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_rdata)
    );

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
    parameter int ADDR_W = 19,
    parameter int LANES  = 3,
    parameter int DATA_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [LANES-1:0]  ram_ce_n,
    input logic              ram_we_n,
    input logic              ram_oe_n,
    input logic [DATA_W-1:0] ram_dq_out,
    input logic              ram_dq_oe
);

    // R2
    turn_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_we_n) |-> !ram_dq_oe);

    // R4
    we_edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> ram_dq_oe && $stable(ram_addr) && $stable(ram_ce_n)
                            && $stable(ram_dq_out));

    // R4
    release_after_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |=> (ram_ce_n == '1) && !ram_dq_oe);

    // R5
    no_fight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> ram_oe_n);

    // R5
    oe_off_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> ram_oe_n);

    // R10
    ready_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_ce_n != '1) |-> !req_ready);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .DATA_W (DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .ram_addr   (ram_addr),
    .ram_ce_n   (ram_ce_n),
    .ram_we_n   (ram_we_n),
    .ram_oe_n   (ram_oe_n),
    .ram_dq_out (ram_dq_out),
    .ram_dq_oe  (ram_dq_oe)
);

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_PS = 5000;
    localparam int PWR_PS = 1_000_000;
    localparam int HZWE = 5000, SD = 5500, PWE = 7000, AW = 7000, WC = 10000;
    localparam int AA = 10000, DOE = 5000, RC = 10000;

    function automatic int cy(input int p);
        int c;
        c = (p + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction
    function automatic int mx(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int NP = cy(PWR_PS);
    localparam int NT = cy(HZWE);
    localparam int ND = mx(mx(cy(SD), cy(PWE) - NT), mx(mx(cy(AW) - NT, cy(WC) - NT - 1), 1));
    localparam int NA = mx(mx(cy(AA), cy(DOE)), cy(RC));

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [23:0] req_wdata = '0;
    logic [2:0]  req_lanes = '0;
    logic        rsp_valid;
    logic [23:0] rsp_rdata;
    logic [18:0] ram_addr;
    logic [2:0]  ram_ce_n;
    logic        ram_we_n, ram_oe_n, ram_dq_oe;
    logic [23:0] ram_dq_out;
    logic [23:0] ram_dq_in = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sram_lane_ctrl #(
        .CLK_PS (CLK_PS), .T_PWRUP_PS (PWR_PS), .T_HZWE_PS (HZWE), .T_SD_PS (SD),
        .T_PWE_PS (PWE), .T_AW_PS (AW), .T_WC_PS (WC), .T_AA_PS (AA),
        .T_DOE_PS (DOE), .T_RC_PS (RC)
    ) dut_i (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_write (req_write), .req_addr (req_addr), .req_wdata (req_wdata),
        .req_lanes (req_lanes), .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .ram_addr (ram_addr), .ram_ce_n (ram_ce_n), .ram_we_n (ram_we_n),
        .ram_oe_n (ram_oe_n), .ram_dq_out (ram_dq_out), .ram_dq_oe (ram_dq_oe),
        .ram_dq_in (ram_dq_in)
    );

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    logic [23:0] ram_mem [int];
    logic [23:0] shadow [int];
    logic [23:0] exp_q [$];
    string       tag_q [$];

    int we_low = 0, drv_cnt = 0, fight_cnt = 0, ce_busy = 0, rd_cnt = 0;
    bit rd_active = 0;
    logic [18:0] rd_addr = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:0] lane_mask(input logic [2:0] ln);
        return {{8{ln[2]}}, {8{ln[1]}}, {8{ln[0]}}};
    endfunction

    // RAM model: data appears only in the last access cycle; filler otherwise
    always @(negedge clk) begin
        bit rc;
        logic [23:0] word;
        rc = rst_n && (ram_ce_n != 3'b111) && !ram_oe_n && ram_we_n;
        if (rc) begin
            if (rd_active && ram_addr == rd_addr) rd_cnt = rd_cnt + 1;
            else rd_cnt = 0;
            rd_active = 1;
            rd_addr = ram_addr;
        end else begin
            rd_active = 0;
        end
        word = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 24'h0;
        for (int l = 0; l < 3; l++) begin
            ram_dq_in[l*8 +: 8] = (rc && rd_cnt >= NA - 1 && !ram_ce_n[l])
                                  ? word[l*8 +: 8] : 8'h5A;
        end
        if (rst_n) begin
            if (!ram_we_n) begin
                we_low++;
                if (ram_dq_oe) drv_cnt++;
            end else begin
                we_low = 0;
                drv_cnt = 0;
            end
            if (ram_dq_oe && !ram_oe_n) fight_cnt++;
            if (!ram_we_n && !ram_oe_n) fight_cnt++;
            if (ram_ce_n != 3'b111) ce_busy++;
        end
    end

    // write end: strobe count, drive count, then store lanes
    always @(posedge ram_we_n) begin
        if (rst_n && ram_ce_n !== 3'b111 && ram_ce_n !== 3'bxxx) begin
            // R2 R3: strobe low NT+ND cycles, driven only in the last ND
            chk(we_low == NT + ND, "R2 strobe length", we_low, NT + ND);
            chk(drv_cnt == ND, "R3 driven cycles", drv_cnt, ND);
            // R4: data still driven at the rising strobe
            chk(ram_dq_oe === 1'b1, "R4 data held at strobe rise", ram_dq_oe, 1);
            begin
                logic [23:0] w;
                w = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : 24'h0;
                for (int l = 0; l < 3; l++)
                    if (!ram_ce_n[l]) w[l*8 +: 8] = ram_dq_out[l*8 +: 8];
                ram_mem[int'(ram_addr)] = w;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R7 unexpected response", rsp_rdata, 0);
            end else begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(rsp_rdata === e, t, rsp_rdata, e);
            end
        end
    end

    task automatic send(input bit wr, input logic [18:0] a, input logic [23:0] d,
                        input logic [2:0] ln, input string tag);
        @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d; req_lanes = ln; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        if (wr) begin
            logic [23:0] old;
            old = shadow.exists(int'(a)) ? shadow[int'(a)] : 24'h0;
            shadow[int'(a)] = (old & ~lane_mask(ln)) | (d & lane_mask(ln));
        end else begin
            logic [23:0] cur;
            cur = shadow.exists(int'(a)) ? shadow[int'(a)] : 24'h0;
            exp_q.push_back(cur & lane_mask(ln));
            tag_q.push_back(tag);
        end
        @(negedge clk);
        req_valid = 1'b0;
        // R10: fields changed after acceptance must not matter
        req_wdata = ~d; req_addr = ~a; req_lanes = ~ln;
    endtask

    task automatic wait_idle();
        while (!req_ready) @(negedge clk);
    endtask

    initial begin
        int n;
        int b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: power-up wait with the bus quiet
        n = 0;
        b = 0;
        while (!req_ready) begin
            if (ram_ce_n != 3'b111 || !ram_we_n || !ram_oe_n || ram_dq_oe) b++;
            @(negedge clk);
            n++;
        end
        chk(n >= NP && n <= NP + 2, "R1 power-up wait", n, NP);
        chk(b == 0, "R1 bus idle during wait", b, 0);

        send(1, 19'h12345, 24'hABCDEF, 3'b111, "R2 full write");
        wait_idle();
        // R7: read latency NA+1 negedges after the accepting edge
        send(0, 19'h12345, 24'h0, 3'b111, "R7 full read");
        n = 1;
        while (!rsp_valid && n < 20) begin
            @(negedge clk);
            n++;
        end
        chk(n == NA + 1, "R7 read latency", n, NA + 1);
        wait_idle();

        send(1, 19'h12345, 24'h007700, 3'b010, "R6 lane write");
        wait_idle();
        send(0, 19'h12345, 24'h0, 3'b111, "R6 neighbours kept");
        wait_idle();
        send(0, 19'h12345, 24'h0, 3'b101, "R8 unselected lane zero");
        wait_idle();
        send(0, 19'h12345, 24'h0, 3'b010, "R8 single lane read");
        wait_idle();

        // R9: zero-mask write touches nothing, ready next cycle
        b = ce_busy;
        send(1, 19'h12345, 24'hFFFFFF, 3'b000, "R9 zero write");
        chk(req_ready === 1'b1, "R9 ready next cycle", req_ready, 1);
        chk(ce_busy == b, "R9 no enable activity", ce_busy - b, 0);
        send(0, 19'h12345, 24'h0, 3'b111, "R9 word unchanged");
        wait_idle();
        // R9: zero-mask read gives zero data one cycle after acceptance
        send(0, 19'h00042, 24'h0, 3'b000, "R9 zero read");
        chk(rsp_valid === 1'b1, "R9 zero read strobe", rsp_valid, 1);
        wait_idle();

        // R10: back-to-back mixed traffic with post-accept field changes
        for (int i = 0; i < 6; i++) begin
            send(1, 19'(i * 1111 + 7), 24'(32'h13579B * (i + 1)), 3'(i + 1), "R10 write");
        end
        send(1, 19'h7FFFF, 24'hC0FFEE, 3'b111, "R10 top address");
        for (int i = 0; i < 6; i++) begin
            send(0, 19'(i * 1111 + 7), 24'h0, 3'b111, "R10 capture readback");
        end
        send(0, 19'h7FFFF, 24'h0, 3'b111, "R10 top address read");
        wait_idle();
        repeat (NA + 4) @(negedge clk);

        chk(exp_q.size() == 0, "R7 all responses seen", exp_q.size(), 0);
        chk(fight_cnt == 0, "R5 no bus fight", fight_cnt, 0);

        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule